// File: doc/BRIEF.md
# Fixed-Point Audio DSP Execution Unit

This block is the arithmetic stage of a 32-bit fixed-point audio signal processor. On each cycle where `in_valid` is high it takes a 4-bit operation code and three signed operands (`op_a`, `op_x`, `op_y`). One clock later it presents a 32-bit result and a set of condition flags. The operations are:

- fractional (Q31) multiply-accumulate, in saturating and wrapping forms and with the product added or subtracted;
- integer multiply-accumulate;
- a three-input add;
- a mask-and-toggle logic operation;
- signed compare-and-select operations;
- linear interpolation;
- a move that also feeds a private 64-bit accumulator.

Operand fetch and result write-back belong to the surrounding pipeline. Log/exponent conversion and the conditional-skip operation are handled elsewhere. For those three codes the unit passes A through unchanged.

The accumulator can be cleared synchronously. Its value is brought out on `acc_out`, so the surrounding datapath can move it into a register.

Top module: `fxalu_core`

## Requirements
- R1: While `rst_n` is low, `result`, `flags`, `out_valid` and `acc_out` all go to zero.
- R2: A valid operation appears on `result` and `flags` one clock after `in_valid`, and `out_valid` is high for that one cycle. Without `in_valid`, `result` and `flags` hold their previous values.
- R3: Code 0x0 gives A + ((X·Y) >>> 31) and code 0x1 gives A + ((−X·Y) >>> 31). Both are computed exactly and clamped to 0x7FFFFFFF / 0x80000000.
- R4: Codes 0x2 and 0x3 compute the same sums as 0x0 and 0x1 but keep only the low 32 bits (wraparound).
- R5: Code 0x4 gives A + X·Y (full integer product) clamped to 32 bits. Code 0x5 gives the same sum wrapped to 31 bits: bits 30..0 of the sum, with bit 31 a copy of bit 30.
- R6: Code 0x6 gives A + X + Y, clamped to 32 bits.
- R7: Code 0x7 returns A and adds (X·Y) >>> 31 to the 64-bit accumulator, wrapping modulo 2^64. `acc_out` shows the new value one clock later.
- R8: Code 0x8 returns (A AND X) XOR Y.
- R9: With A and Y compared as signed values: code 0x9 returns X if A ≥ Y, else NOT X; code 0xA returns X if A ≥ Y, else Y; code 0xB returns X if A < Y, else Y.
- R10: Code 0xE gives A + ((X·(Y − A)) >>> 31), computed exactly and clamped to 32 bits.
- R11: Codes 0xC, 0xD and 0xF return A and leave the accumulator unchanged.
- R12: `flags` bit positions:
  - bit 0 = normalized (result bit 31 differs from bit 30);
  - bit 1 = borrow (set only for codes 0x9–0xB when A < Y signed);
  - bit 2 = minus (result bit 31);
  - bit 3 = zero (result is 0);
  - bit 4 = saturate (clamping occurred in this operation);
  - bit 8 = nonzero (result is not 0);
  - bits 5–7 = 0.
- R13: `acc_clear` zeroes the accumulator at the next clock edge and takes priority over a same-cycle code 0x7 accumulate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 4 | Operation code |
| op_a | input | 32 | Operand A |
| op_x | input | 32 | Operand X |
| op_y | input | 32 | Operand Y |
| acc_clear | input | 1 | Synchronous accumulator clear |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 32 | Registered result |
| flags | output | 9 | Registered condition flags |
| acc_out | output | 64 | Accumulator value |

## Verification
The operations are driven with four operand mixes:

- full-range random words, which exercise carries across the whole width and frequent clamping;
- small signed values, which keep the fractional products near zero and so show whether the shift is arithmetic;
- the extreme set (0, ±1, full-scale positive and negative, half-scale), which separates saturating from wrapping forms and hits the single overflowing product −1.0 × −1.0;
- mid-range Q31 values, which show that the fractional scaling is exact.

Directed cases add equal A and Y at the compare boundary, an accumulate chain followed by a clear, a clear in the same cycle as an accumulate, and idle cycles where the outputs must hold.

// File: rtl/fxalu_pkg.sv
package fxalu_pkg;
  localparam int DW     = 32;
  localparam int WIDE_W = 64;
  localparam int ACC_W  = 64;
  localparam int FLAG_W = 9;
  localparam int QSHIFT = DW - 1;

  localparam int FL_NORM    = 0;
  localparam int FL_BORROW  = 1;
  localparam int FL_MINUS   = 2;
  localparam int FL_ZERO    = 3;
  localparam int FL_SAT     = 4;
  localparam int FL_NONZERO = 8;

  typedef enum logic [3:0] {
    OP_MACS   = 4'h0, OP_MACNS = 4'h1, OP_MACW  = 4'h2, OP_MACNW  = 4'h3,
    OP_IMACS  = 4'h4, OP_IMACW = 4'h5, OP_ADD3  = 4'h6, OP_MACMV  = 4'h7,
    OP_ANDXOR = 4'h8, OP_TSTNG = 4'h9, OP_LIMGE = 4'hA, OP_LIMLT  = 4'hB,
    OP_LOGC   = 4'hC, OP_EXPC  = 4'hD, OP_INTRP = 4'hE, OP_SKIPC  = 4'hF
  } op_e;

  typedef struct packed {
    logic          sat;
    logic [DW-1:0] val;
  } clamp_t;

  function automatic logic signed [WIDE_W-1:0] sext(input logic [DW-1:0] v);
    return {{(WIDE_W-DW){v[DW-1]}}, v};
  endfunction

  function automatic clamp_t clamp_wide(input logic signed [WIDE_W-1:0] v);
    logic signed [WIDE_W-1:0] hi, lo;
    clamp_t c;
    hi = sext({1'b0, {(DW-1){1'b1}}});
    lo = sext({1'b1, {(DW-1){1'b0}}});
    if (v > hi) begin
      c.sat = 1'b1; c.val = hi[DW-1:0];
    end else if (v < lo) begin
      c.sat = 1'b1; c.val = lo[DW-1:0];
    end else begin
      c.sat = 1'b0; c.val = v[DW-1:0];
    end
    return c;
  endfunction

  function automatic logic signed [WIDE_W-1:0] q_scale(input logic signed [WIDE_W-1:0] p);
    return p >>> QSHIFT;
  endfunction
endpackage

// File: rtl/fxalu_arith.sv
module fxalu_arith
  import fxalu_pkg::*;
(
  input  op_e                       op,
  input  logic [DW-1:0]             a,
  input  logic [DW-1:0]             x,
  input  logic [DW-1:0]             y,
  output logic [DW-1:0]             res,
  output logic                      sat,
  output logic signed [WIDE_W-1:0]  frac_prod
);
  logic signed [WIDE_W-1:0] ae, xe, ye, prod, diff, iprod, sum;
  clamp_t cl;

  always_comb begin
    ae    = sext(a);
    xe    = sext(x);
    ye    = sext(y);
    prod  = xe * ye;
    diff  = ye - ae;
    iprod = xe * diff;
    sum   = '0;
    res   = a;
    sat   = 1'b0;
    unique case (op)
      OP_MACS, OP_MACW:   sum = ae + q_scale(prod);
      OP_MACNS, OP_MACNW: sum = ae + q_scale(-prod);
      OP_IMACS, OP_IMACW: sum = ae + prod;
      OP_ADD3:            sum = ae + xe + ye;
      OP_INTRP:           sum = ae + q_scale(iprod);
      default:            sum = ae;
    endcase
    cl = clamp_wide(sum);
    unique case (op)
      OP_MACS, OP_MACNS, OP_IMACS, OP_ADD3, OP_INTRP: begin
        res = cl.val;
        sat = cl.sat;
      end
      OP_MACW, OP_MACNW: res = sum[DW-1:0];
      OP_IMACW:          res = {sum[DW-2], sum[DW-2:0]};
      default:           res = a;
    endcase
  end

  assign frac_prod = q_scale(prod);
endmodule

// File: rtl/fxalu_select.sv
module fxalu_select
  import fxalu_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  output logic [DW-1:0] res,
  output logic          borrow
);
  logic a_ge_y;
  assign a_ge_y = $signed(a) >= $signed(y);

  always_comb begin
    res    = a;
    borrow = 1'b0;
    unique case (op)
      OP_ANDXOR: res = (a & x) ^ y;
      OP_TSTNG: begin res = a_ge_y ? x : ~x; borrow = ~a_ge_y; end
      OP_LIMGE: begin res = a_ge_y ? x : y;  borrow = ~a_ge_y; end
      OP_LIMLT: begin res = a_ge_y ? y : x;  borrow = ~a_ge_y; end
      default:  res = a;
    endcase
  end
endmodule

// File: rtl/fxalu_acc.sv
module fxalu_acc
  import fxalu_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      add_en,
  input  logic signed [WIDE_W-1:0]  addend,
  output logic [ACC_W-1:0]          acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (clr)    acc <= '0;
    else if (add_en) acc <= acc + ACC_W'(addend);
  end

  // R13
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0));

  // R11
  acc_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !add_en) |=> $stable(acc));
endmodule

// File: rtl/fxalu_core.sv
module fxalu_core
  import fxalu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        opcode,
  input  logic [DW-1:0]     op_a,
  input  logic [DW-1:0]     op_x,
  input  logic [DW-1:0]     op_y,
  input  logic              acc_clear,
  output logic              out_valid,
  output logic [DW-1:0]     result,
  output logic [FLAG_W-1:0] flags,
  output logic [ACC_W-1:0]  acc_out
);
  op_e                      op;
  logic [DW-1:0]            arith_res, sel_res, next_res;
  logic                     arith_sat, sel_borrow, use_sel;
  logic signed [WIDE_W-1:0] frac_prod;
  logic [FLAG_W-1:0]        next_flags;
  logic                     acc_add;

  assign op = op_e'(opcode);

  fxalu_arith u_arith (
    .op(op), .a(op_a), .x(op_x), .y(op_y),
    .res(arith_res), .sat(arith_sat), .frac_prod(frac_prod)
  );

  fxalu_select u_sel (
    .op(op), .a(op_a), .x(op_x), .y(op_y),
    .res(sel_res), .borrow(sel_borrow)
  );

  assign acc_add = in_valid && (op == OP_MACMV);

  fxalu_acc u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clear), .add_en(acc_add),
    .addend(frac_prod), .acc(acc_out)
  );

  assign use_sel  = (opcode[3:2] == 2'b10);
  assign next_res = use_sel ? sel_res : arith_res;

  always_comb begin
    next_flags             = '0;
    next_flags[FL_NORM]    = next_res[DW-1] ^ next_res[DW-2];
    next_flags[FL_BORROW]  = use_sel & sel_borrow;
    next_flags[FL_MINUS]   = next_res[DW-1];
    next_flags[FL_ZERO]    = (next_res == '0);
    next_flags[FL_SAT]     = ~use_sel & arith_sat;
    next_flags[FL_NONZERO] = (next_res != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= next_res;
        flags  <= next_flags;
      end
    end
  end

  // R2
  out_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flags) && !out_valid));

  // R12
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[FL_SAT] |-> (result == {1'b0, {(DW-1){1'b1}}} ||
                       result == {1'b1, {(DW-1){1'b0}}}));

  // R12
  zero_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags[FL_ZERO] != flags[FL_NONZERO]));

  // R11
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_LOGC || op == OP_EXPC || op == OP_SKIPC))
      |=> (result == $past(op_a)));
endmodule

// File: tb/fxalu_core_test.sv
module fxalu_core_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, acc_clear;
  logic [3:0]  opcode;
  logic [31:0] op_a, op_x, op_y;
  logic        out_valid;
  logic [31:0] result;
  logic [8:0]  flags;
  logic [63:0] acc_out;

  int checks = 0;
  int failures = 0;
  logic [63:0] acc_model = 64'd0;
  logic [31:0] last_res = 32'd0;
  logic [8:0]  last_flg = 9'd0;

  always #2.5 clk = ~clk;

  fxalu_core uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .op_a(op_a), .op_x(op_x), .op_y(op_y), .acc_clear(acc_clear),
    .out_valid(out_valid), .result(result), .flags(flags), .acc_out(acc_out)
  );

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'h0, 4'h1: return "R3";
      4'h2, 4'h3: return "R4";
      4'h4, 4'h5: return "R5";
      4'h6:       return "R6";
      4'h7:       return "R7";
      4'h8:       return "R8";
      4'h9, 4'hA, 4'hB: return "R9";
      4'hE:       return "R10";
      default:    return "R11";
    endcase
  endfunction

  // clamp a 64-bit signed value into 32 bits, reporting whether it was clipped
  function automatic logic [32:0] limit(input longint v);
    if (v > 64'sd2147483647)  return {1'b1, 32'h7FFFFFFF};
    if (v < -64'sd2147483648) return {1'b1, 32'h80000000};
    return {1'b0, v[31:0]};
  endfunction

  function automatic longint frac_of(input longint p);
    return p >>> 31;
  endfunction

  // model: {borrow, sat, result}
  function automatic logic [33:0] model(input logic [3:0] op,
                                        input logic [31:0] a, x, y);
    longint la, lx, ly, s;
    logic [32:0] c;
    logic lt;
    la = longint'($signed(a)); lx = longint'($signed(x)); ly = longint'($signed(y));
    lt = la < ly;
    case (op)
      4'h0: begin c = limit(la + frac_of(lx * ly));  return {1'b0, c}; end
      4'h1: begin c = limit(la + frac_of(-(lx * ly))); return {1'b0, c}; end
      4'h2: begin s = la + frac_of(lx * ly);  return {2'b00, s[31:0]}; end
      4'h3: begin s = la + frac_of(-(lx * ly)); return {2'b00, s[31:0]}; end
      4'h4: begin c = limit(la + lx * ly); return {1'b0, c}; end
      4'h5: begin s = la + lx * ly; return {2'b00, s[30], s[30:0]}; end
      4'h6: begin c = limit(la + lx + ly); return {1'b0, c}; end
      4'h8: return {2'b00, (a & x) ^ y};
      4'h9: return {lt, 1'b0, lt ? ~x : x};
      4'hA: return {lt, 1'b0, lt ? y : x};
      4'hB: return {lt, 1'b0, lt ? x : y};
      4'hE: begin c = limit(la + frac_of(lx * (ly - la))); return {1'b0, c}; end
      default: return {2'b00, a};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic exec(input logic [3:0] op, input logic [31:0] a, x, y,
                      input bit clr);
    logic [33:0] m;
    logic [8:0] ef;
    m = model(op, a, x, y);
    ef = 9'd0;
    ef[0] = m[31] ^ m[30];
    ef[1] = m[33];
    ef[2] = m[31];
    ef[3] = (m[31:0] == 32'd0);
    ef[4] = m[32];
    ef[8] = (m[31:0] != 32'd0);
    opcode = op; op_a = a; op_x = x; op_y = y; in_valid = 1'b1; acc_clear = clr;
    @(negedge clk);
    in_valid = 1'b0; acc_clear = 1'b0;
    if (clr) acc_model = 64'd0;  // R13 clear wins over accumulate
    else if (op == 4'h7)
      acc_model = acc_model + 64'(frac_of(longint'($signed(x)) * longint'($signed(y))));
    check(out_valid == 1'b1, "R2", "out_valid pulse", 64'(out_valid), 64'd1);
    check(result == m[31:0], req_of(op), "result", 64'(result), 64'(m[31:0]));
    check(flags == ef, "R12", "flags", 64'(flags), 64'(ef));
    check(acc_out == acc_model, (clr ? "R13" : "R7"), "accumulator", acc_out, acc_model);
    last_res = result; last_flg = flags;
  endtask

  task automatic idle_check();
    @(negedge clk);
    check(out_valid == 1'b0 && result == last_res && flags == last_flg,
          "R2", "hold without strobe", {32'(out_valid), result}, {32'd0, last_res});
  endtask

  function automatic logic [31:0] pick(input int mode);
    logic [31:0] ext [6];
    ext = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 32'h40000000};
    case (mode)
      0: return $urandom;
      1: return 32'($signed(8'($urandom)));
      2: return ext[$urandom_range(5, 0)];
      default: return 32'($signed(28'($urandom)));
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; acc_clear = 1'b0;
    opcode = 4'h0; op_a = '0; op_x = '0; op_y = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(result == 0 && flags == 0 && out_valid == 0 && acc_out == 0, "R1",
          "reset state", {32'(flags), result}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner cases
    exec(4'h0, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 0);  // R3 positive clamp
    exec(4'h1, 32'h80000000, 32'h7FFFFFFF, 32'h7FFFFFFF, 0);  // R3 negative clamp
    exec(4'h0, 32'h0, 32'h80000000, 32'h80000000, 0);         // R3 -1 x -1
    exec(4'h2, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 0);  // R4 wraps
    exec(4'h3, 32'h00000010, 32'h00000003, 32'h00000005, 0);  // R4 small negative
    exec(4'h4, 32'h7FFFFF00, 32'h00010000, 32'h00010000, 0);  // R5 clamp
    exec(4'h5, 32'h3FFFFFFF, 32'h00000001, 32'h00000001, 0);  // R5 31-bit wrap
    exec(4'h6, 32'h80000000, 32'h80000000, 32'hFFFFFFFF, 0);  // R6 negative clamp
    exec(4'h8, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0F0F0F0F, 0);  // R8
    exec(4'h9, 32'h00000005, 32'h12345678, 32'h00000005, 0);  // R9 equal boundary
    exec(4'h9, 32'hFFFFFFFF, 32'h12345678, 32'h00000001, 0);  // R9 signed less
    exec(4'hA, 32'h80000000, 32'h11111111, 32'h7FFFFFFF, 0);  // R9
    exec(4'hB, 32'h80000000, 32'h11111111, 32'h7FFFFFFF, 0);  // R9
    exec(4'hE, 32'h00000000, 32'h40000000, 32'h40000000, 0);  // R10 half way
    exec(4'hE, 32'h80000000, 32'h7FFFFFFF, 32'h7FFFFFFF, 0);  // R10 full swing
    exec(4'hC, 32'hCAFEF00D, 32'h7FFFFFFF, 32'h7FFFFFFF, 0);  // R11
    exec(4'hD, 32'h00000000, 32'h7FFFFFFF, 32'h7FFFFFFF, 0);  // R11
    exec(4'hF, 32'h13572468, 32'h7FFFFFFF, 32'h7FFFFFFF, 0);  // R11
    idle_check();
    // R7 accumulate chain
    exec(4'h7, 32'hAAAA5555, 32'h7FFFFFFF, 32'h7FFFFFFF, 0);
    exec(4'h7, 32'h00000001, 32'h80000000, 32'h80000000, 0);
    exec(4'h7, 32'h00000002, 32'h80000000, 32'h7FFFFFFF, 0);
    idle_check();
    exec(4'h0, 32'h00000000, 32'h00000000, 32'h00000000, 1);  // R13 plain clear
    exec(4'h7, 32'h00000003, 32'h40000000, 32'h40000000, 0);
    exec(4'h7, 32'h00000004, 32'h40000000, 32'h40000000, 1);  // R13 priority

    for (int i = 0; i < 400; i++) begin
      int mode;
      logic [3:0] op;
      mode = $urandom_range(3, 0);
      op = 4'($urandom);
      exec(op, pick(mode), pick(mode), pick(mode), ($urandom_range(19, 0) == 0));
      if ($urandom_range(7, 0) == 0) idle_check();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule